// File: doc/BRIEF.md
# Temperature Limit Status Alert Controller

This block watches several temperature channels. It compares each new reading against a high limit, a low limit and a thermal limit that software programs for that channel. Hits are recorded in per-channel status registers that hold their value until they are read. A summary status register ORs those bits together and also carries a live converter-busy flag and a hardware shutdown flag. The block drives three outputs: an ALERT output, a thermal output that follows the live over-thermal-limit state, and a system-shutdown output taken from the first external channel.

Each reading arrives as an 11-bit code with 0.125 degree steps. A strobe marks it valid and a channel index names its channel. Software selects one of two ranges. The normal range uses plain binary from 0 to +127.875 degrees, and codes above it saturate. The extended range uses offset binary (true value plus 64 degrees) from -64 to +191.875 degrees. Limits are held in the same encoding as the readings.

ALERT comes from a three-state machine. AL_IDLE moves to AL_INT (interrupt mode) when a high, low or fault summary bit is set and ALERT is not masked. AL_IDLE moves to AL_CMP (comparator mode) when any channel has tripped its high limit. AL_INT returns to AL_IDLE when the summary bits clear, when the mask is set, or when comparator mode is selected; in that last case it goes to AL_CMP instead if a channel is tripped. AL_CMP returns to AL_IDLE when no channel is tripped or when interrupt mode is selected. Each channel has its own two-state tracker. CMP_CLEAR moves to CMP_TRIP when a reading is above the high limit. CMP_TRIP moves back to CMP_CLEAR when a reading is below the high limit minus 10 degrees.

Top module: `tls_alert_ctrl`

## Requirements
- R1: After reset, the configuration register (address 0x00) reads 0x00, the summary status register reads 0x00, and alert, therm_out and sys_shdn are low. The high and thermal limits reset to 0x7FF and the low limits reset to 0x000.
- R2: The summary status register (address 0x01, read-only) has these bits: bit 7 = conv_busy (live), bit 4 = any high status, bit 3 = any low status, bit 2 = any fault status, bit 1 = any thermal status, bit 0 = shutdown.
- R3: On a valid reading for channel c, the high bit c is set when the code is strictly greater than the channel's high limit. The low bit c is set when the code is strictly less than the low limit. A reading equal to a limit sets nothing. Set bits stay set until cleared.
- R4: A read of a per-channel status register returns one bit per channel in bits [NCH-1:0] and clears that register, together with its summary bit. The registers are high at 0x02, low at 0x03, thermal at 0x04 and fault at 0x05. Limit registers read back what was written: high at 0x08+c, low at 0x0C+c, thermal at 0x10+c.
- R5: In interrupt mode (config bit 5 = 0), alert rises one clock after a high, low or fault summary bit becomes set and stays high until those bits clear. conv_busy, the thermal bits and the shutdown bit never drive alert.
- R6: Config bit 7 = 1 keeps alert low in interrupt mode, while the status registers go on updating.
- R7: Config bit 5 = 1 selects comparator mode. In this mode alert follows the per-channel high trip state regardless of the per-channel status registers and of config bit 7. A channel releases only on a reading strictly below its high limit minus 80 codes.
- R8: Config bit 2 = 0 saturates reading codes above 1023 to 1023 before any comparison. Config bit 2 = 1 compares the full 11-bit offset-binary code.
- R9: Each reading of channel 1 sets sys_shdn and status bit 0 when the code exceeds the shutdown threshold, and clears them otherwise. The threshold is 800 in the normal range and 1312 in the extended range. Readings of other channels leave sys_shdn unchanged.
- R10: therm_out is high while the latest reading of any channel is above that channel's thermal limit. The thermal status bit stays set after the temperature falls.
- R11: diode_fault[c] latches fault bit c only for external channels (c >= 1). A fault on channel 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| temp_valid | input | 1 | New reading present this cycle |
| temp_sel | input | CW | Channel index of the reading |
| temp_code | input | TW | Reading code, 0.125 degree steps |
| conv_busy | input | 1 | Converter is busy |
| diode_fault | input | NCH | Per-channel diode fault flags |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears read-to-clear registers) |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | TW | Write data |
| bus_rdata | output | TW | Read data, valid in the same cycle as bus_rd |
| alert | output | 1 | ALERT output |
| therm_out | output | 1 | Live over-thermal-limit indication |
| sys_shdn | output | 1 | System shutdown request |

## Verification
The assertions assume a single bus strobe per cycle, a temp_sel that never names a channel at or beyond NCH, and a configuration that stays stable while a reading is being judged. The directed stimulus drives one bus access or one reading at a time, changes inputs only on falling edges, and uses channel indices 0 to 2 only. It releases diode_fault before reading the fault register, so a set never meets a clear in the same cycle unless a test intends it.

// File: rtl/tls_pkg.sv
`timescale 1ns/1ps
package tls_pkg;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] A_CFG   = 5'h00;
    localparam logic [ADDR_W-1:0] A_STAT  = 5'h01;
    localparam logic [ADDR_W-1:0] A_HIST  = 5'h02;
    localparam logic [ADDR_W-1:0] A_LOST  = 5'h03;
    localparam logic [ADDR_W-1:0] A_THST  = 5'h04;
    localparam logic [ADDR_W-1:0] A_FLST  = 5'h05;
    localparam logic [ADDR_W-1:0] A_HILIM = 5'h08;
    localparam logic [ADDR_W-1:0] A_LOLIM = 5'h0C;
    localparam logic [ADDR_W-1:0] A_THLIM = 5'h10;

    localparam int CFG_MASK  = 7;
    localparam int CFG_CMP   = 5;
    localparam int CFG_RANGE = 2;

    typedef enum logic [1:0] {
        AL_IDLE = 2'd0,
        AL_INT  = 2'd1,
        AL_CMP  = 2'd2
    } alert_state_t;

    typedef enum logic {
        CMP_CLEAR = 1'b0,
        CMP_TRIP  = 1'b1
    } trip_state_t;
endpackage

// File: rtl/tls_regs.sv
`timescale 1ns/1ps
module tls_regs
    import tls_pkg::*;
#(
    parameter int NCH = 3,
    parameter int TW  = 11
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic                    rd_en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [TW-1:0]           wdata,
    output logic [TW-1:0]           rdata,
    output logic                    cfg_mask,
    output logic                    cfg_cmp,
    output logic                    cfg_range,
    output logic [NCH-1:0][TW-1:0]  hi_lim,
    output logic [NCH-1:0][TW-1:0]  lo_lim,
    output logic [NCH-1:0][TW-1:0]  th_lim,
    input  logic                    busy,
    input  logic                    shdn,
    input  logic [NCH-1:0]          hi_st,
    input  logic [NCH-1:0]          lo_st,
    input  logic [NCH-1:0]          th_st,
    input  logic [NCH-1:0]          flt_st,
    output logic                    clr_hi,
    output logic                    clr_lo,
    output logic                    clr_th,
    output logic                    clr_flt
);
    localparam logic [TW-1:0] LIM_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_mask  <= 1'b0;
            cfg_cmp   <= 1'b0;
            cfg_range <= 1'b0;
        end else if (wr_en && addr == A_CFG) begin
            cfg_mask  <= wdata[CFG_MASK];
            cfg_cmp   <= wdata[CFG_CMP];
            cfg_range <= wdata[CFG_RANGE];
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_lim
        localparam logic [ADDR_W-1:0] AH = A_HILIM + ADDR_W'(g);
        localparam logic [ADDR_W-1:0] AL = A_LOLIM + ADDR_W'(g);
        localparam logic [ADDR_W-1:0] AT = A_THLIM + ADDR_W'(g);
        always_ff @(posedge clk) begin
            if (rst) begin
                hi_lim[g] <= LIM_MAX;
                lo_lim[g] <= '0;
                th_lim[g] <= LIM_MAX;
            end else if (wr_en) begin
                if (addr == AH) hi_lim[g] <= wdata;
                if (addr == AL) lo_lim[g] <= wdata;
                if (addr == AT) th_lim[g] <= wdata;
            end
        end
    end

    assign clr_hi  = rd_en && addr == A_HIST;
    assign clr_lo  = rd_en && addr == A_LOST;
    assign clr_th  = rd_en && addr == A_THST;
    assign clr_flt = rd_en && addr == A_FLST;

    always_comb begin
        rdata = '0;
        if (addr == A_CFG) begin
            rdata[CFG_MASK]  = cfg_mask;
            rdata[CFG_CMP]   = cfg_cmp;
            rdata[CFG_RANGE] = cfg_range;
        end else if (addr == A_STAT) begin
            rdata[7] = busy;
            rdata[4] = |hi_st;
            rdata[3] = |lo_st;
            rdata[2] = |flt_st;
            rdata[1] = |th_st;
            rdata[0] = shdn;
        end else if (addr == A_HIST) begin
            rdata[NCH-1:0] = hi_st;
        end else if (addr == A_LOST) begin
            rdata[NCH-1:0] = lo_st;
        end else if (addr == A_THST) begin
            rdata[NCH-1:0] = th_st;
        end else if (addr == A_FLST) begin
            rdata[NCH-1:0] = flt_st;
        end else begin
            for (int c = 0; c < NCH; c++) begin
                if (addr == A_HILIM + ADDR_W'(c)) rdata = hi_lim[c];
                if (addr == A_LOLIM + ADDR_W'(c)) rdata = lo_lim[c];
                if (addr == A_THLIM + ADDR_W'(c)) rdata = th_lim[c];
            end
        end
    end

    // R1: configuration returns to zero after reset
    p_cfg_reset_r1: assert property (@(posedge clk)
        $past(rst) |-> (!cfg_mask && !cfg_cmp && !cfg_range));
endmodule

// File: rtl/tls_chan.sv
`timescale 1ns/1ps
module tls_chan
    import tls_pkg::*;
#(
    parameter int TW     = 11,
    parameter int HYST   = 80,
    parameter bit IS_EXT = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          upd,
    input  logic [TW-1:0] code,
    input  logic [TW-1:0] hi_lim,
    input  logic [TW-1:0] lo_lim,
    input  logic [TW-1:0] th_lim,
    input  logic          fault,
    input  logic          clr_hi,
    input  logic          clr_lo,
    input  logic          clr_th,
    input  logic          clr_flt,
    output logic          hi_st,
    output logic          lo_st,
    output logic          th_st,
    output logic          flt_st,
    output logic          th_live,
    output logic          cmp_act
);
    trip_state_t   trip_q, trip_d;
    logic [TW-1:0] rel_lim;
    logic          is_hi, is_lo, is_th, flt_in;

    assign is_hi   = code > hi_lim;
    assign is_lo   = code < lo_lim;
    assign is_th   = code > th_lim;
    assign flt_in  = IS_EXT ? fault : 1'b0;
    assign rel_lim = (hi_lim >= TW'(HYST)) ? hi_lim - TW'(HYST) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_st   <= 1'b0;
            lo_st   <= 1'b0;
            th_st   <= 1'b0;
            flt_st  <= 1'b0;
            th_live <= 1'b0;
        end else begin
            hi_st  <= (upd && is_hi) || (hi_st  && !clr_hi);
            lo_st  <= (upd && is_lo) || (lo_st  && !clr_lo);
            th_st  <= (upd && is_th) || (th_st  && !clr_th);
            flt_st <= flt_in         || (flt_st && !clr_flt);
            if (upd) th_live <= is_th;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) trip_q <= CMP_CLEAR;
        else     trip_q <= trip_d;
    end

    always_comb begin
        trip_d = trip_q;
        unique case (trip_q)
            CMP_CLEAR: if (upd && is_hi)            trip_d = CMP_TRIP;
            CMP_TRIP:  if (upd && code < rel_lim)   trip_d = CMP_CLEAR;
            default:                                trip_d = CMP_CLEAR;
        endcase
    end

    always_comb cmp_act = (trip_q == CMP_TRIP);

    // R3: a set high bit holds until its register is read
    p_hi_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        (hi_st && !clr_hi) |=> hi_st);
    // R3: a reading at or below the limit never raises a clear high bit
    p_hi_strict_r3: assert property (@(posedge clk) disable iff (rst)
        (!hi_st && !(upd && code > hi_lim)) |=> !hi_st);
    // R4: reading clears the bit when no new exceed arrives
    p_hi_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (clr_hi && !upd) |=> !hi_st);
    // R7: the trip state only leaves on a reading
    p_trip_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !upd |=> $stable(cmp_act));
endmodule

// File: rtl/tls_alert_fsm.sv
`timescale 1ns/1ps
module tls_alert_fsm
    import tls_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cmp_mode,
    input  logic mask,
    input  logic int_cond,
    input  logic cmp_cond,
    output logic alert
);
    alert_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= AL_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            AL_IDLE: begin
                if (cmp_mode && cmp_cond)                state_d = AL_CMP;
                else if (!cmp_mode && !mask && int_cond) state_d = AL_INT;
            end
            AL_INT: begin
                if (cmp_mode)                state_d = cmp_cond ? AL_CMP : AL_IDLE;
                else if (mask || !int_cond)  state_d = AL_IDLE;
            end
            AL_CMP: begin
                if (!cmp_mode || !cmp_cond)  state_d = AL_IDLE;
            end
            default: state_d = AL_IDLE;
        endcase
    end

    always_comb alert = (state_q != AL_IDLE);

    // R5: alert only follows a qualifying condition in the previous cycle
    p_alert_cause_r5: assert property (@(posedge clk) disable iff (rst)
        alert |-> $past((!cmp_mode && !mask && int_cond) || (cmp_mode && cmp_cond)));
    // R6: mask keeps alert low in interrupt mode
    p_mask_r6: assert property (@(posedge clk) disable iff (rst)
        (mask && !cmp_mode) |=> !alert);
    // R7: comparator mode ignores mask and follows the trip state
    p_cmp_follow_r7: assert property (@(posedge clk) disable iff (rst)
        (cmp_mode && cmp_cond) |=> alert);
endmodule

// File: rtl/tls_alert_ctrl.sv
`timescale 1ns/1ps
module tls_alert_ctrl
    import tls_pkg::*;
#(
    parameter int NCH      = 3,
    parameter int TW       = 11,
    parameter int FRAC     = 3,
    parameter int HYST_DEG = 10,
    parameter int SHDN_DEG = 100,
    parameter int SHDN_CH  = 1,
    localparam int CW      = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              temp_valid,
    input  logic [CW-1:0]     temp_sel,
    input  logic [TW-1:0]     temp_code,
    input  logic              conv_busy,
    input  logic [NCH-1:0]    diode_fault,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [TW-1:0]     bus_wdata,
    output logic [TW-1:0]     bus_rdata,
    output logic              alert,
    output logic              therm_out,
    output logic              sys_shdn
);
    localparam int NORM_MAX = (1 << (TW - 1)) - 1;
    localparam int EXT_OFF  = 64 << FRAC;
    localparam int HYST     = HYST_DEG << FRAC;
    localparam int SHDN_N   = SHDN_DEG << FRAC;

    logic                   cfg_mask, cfg_cmp, cfg_range;
    logic [NCH-1:0][TW-1:0] hi_lim, lo_lim, th_lim;
    logic [NCH-1:0]         hi_st, lo_st, th_st, flt_st, th_live, cmp_act;
    logic                   clr_hi, clr_lo, clr_th, clr_flt;
    logic [TW-1:0]          eff_code, shdn_lim;
    logic                   shdn_q, shdn_upd;

    assign eff_code = cfg_range ? temp_code
                    : ((temp_code > TW'(NORM_MAX)) ? TW'(NORM_MAX) : temp_code);
    assign shdn_lim = cfg_range ? TW'(SHDN_N + EXT_OFF) : TW'(SHDN_N);
    assign shdn_upd = temp_valid && (temp_sel == CW'(SHDN_CH));

    always_ff @(posedge clk) begin
        if (rst)           shdn_q <= 1'b0;
        else if (shdn_upd) shdn_q <= eff_code > shdn_lim;
    end

    tls_regs #(.NCH(NCH), .TW(TW)) u_regs (
        .clk(clk), .rst(rst),
        .wr_en(bus_wr), .rd_en(bus_rd), .addr(bus_addr),
        .wdata(bus_wdata), .rdata(bus_rdata),
        .cfg_mask(cfg_mask), .cfg_cmp(cfg_cmp), .cfg_range(cfg_range),
        .hi_lim(hi_lim), .lo_lim(lo_lim), .th_lim(th_lim),
        .busy(conv_busy), .shdn(shdn_q),
        .hi_st(hi_st), .lo_st(lo_st), .th_st(th_st), .flt_st(flt_st),
        .clr_hi(clr_hi), .clr_lo(clr_lo), .clr_th(clr_th), .clr_flt(clr_flt)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        tls_chan #(.TW(TW), .HYST(HYST), .IS_EXT(g != 0)) u_chan (
            .clk(clk), .rst(rst),
            .upd(temp_valid && temp_sel == CW'(g)),
            .code(eff_code),
            .hi_lim(hi_lim[g]), .lo_lim(lo_lim[g]), .th_lim(th_lim[g]),
            .fault(diode_fault[g]),
            .clr_hi(clr_hi), .clr_lo(clr_lo), .clr_th(clr_th), .clr_flt(clr_flt),
            .hi_st(hi_st[g]), .lo_st(lo_st[g]), .th_st(th_st[g]),
            .flt_st(flt_st[g]), .th_live(th_live[g]), .cmp_act(cmp_act[g])
        );
    end

    tls_alert_fsm u_fsm (
        .clk(clk), .rst(rst),
        .cmp_mode(cfg_cmp), .mask(cfg_mask),
        .int_cond(|hi_st || |lo_st || |flt_st),
        .cmp_cond(|cmp_act),
        .alert(alert)
    );

    assign therm_out = |th_live;
    assign sys_shdn  = shdn_q;

    // R9: shutdown only moves on a reading of the shutdown channel
    p_shdn_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !shdn_upd |=> $stable(sys_shdn));
    // R11: a fault on the internal channel never latches
    p_int_fault_r11: assert property (@(posedge clk) disable iff (rst)
        (!flt_st[0]) |=> !flt_st[0]);
endmodule

// File: tb/test_tls_alert_ctrl.sv
`timescale 1ns/1ps
module test_tls_alert_ctrl;
    import tls_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        temp_valid = 1'b0;
    logic [1:0]  temp_sel = '0;
    logic [10:0] temp_code = '0;
    logic        conv_busy = 1'b0;
    logic [2:0]  diode_fault = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [10:0] bus_wdata = '0;
    logic [10:0] bus_rdata;
    logic        alert, therm_out, sys_shdn;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    tls_alert_ctrl i_tls_alert_ctrl (
        .clk(clk), .rst(rst),
        .temp_valid(temp_valid), .temp_sel(temp_sel), .temp_code(temp_code),
        .conv_busy(conv_busy), .diode_fault(diode_fault),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .alert(alert), .therm_out(therm_out), .sys_shdn(sys_shdn)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input int d);
        @(negedge clk);
        bus_addr = a; bus_wdata = 11'(d); bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output int d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #2 d = int'(bus_rdata);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic sample(input int ch, input int code);
        @(negedge clk);
        temp_sel = 2'(ch); temp_code = 11'(code); temp_valid = 1'b1;
        @(negedge clk);
        temp_valid = 1'b0;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic t_reset();
        int d;
        rd(A_CFG, d);   chk("R1 cfg", d, 0);
        rd(A_STAT, d);  chk("R1 status", d, 0);
        rd(A_HILIM, d); chk("R1 high limit", d, 'h7FF);
        chk("R1 alert", alert, 0);
        chk("R1 therm_out", therm_out, 0);
        chk("R1 sys_shdn", sys_shdn, 0);
    endtask

    task automatic t_high_low();
        int d;
        wr(A_HILIM, 400);
        rd(A_HILIM, d); chk("R4 limit readback", d, 400);
        sample(0, 400);
        rd(A_STAT, d);  chk("R3 equal to high limit", d, 'h00);
        sample(0, 401);
        step();
        chk("R5 alert on high", alert, 1);
        rd(A_STAT, d);  chk("R2 high summary bit4", d, 'h10);
        rd(A_HIST, d);  chk("R4 high register", d, 'h1);
        step();
        chk("R5 alert released", alert, 0);
        rd(A_STAT, d);  chk("R4 summary cleared", d, 'h00);
        conv_busy = 1'b1;
        rd(A_STAT, d);  chk("R2 busy bit7", d, 'h80);
        step();
        chk("R5 busy no alert", alert, 0);
        conv_busy = 1'b0;
        wr(A_LOLIM + 5'd2, 100);
        sample(2, 100);
        rd(A_STAT, d);  chk("R3 equal to low limit", d, 'h00);
        sample(2, 99);
        rd(A_STAT, d);  chk("R2 low summary bit3", d, 'h08);
        rd(A_LOST, d);  chk("R4 low register", d, 'h4);
        step();
        chk("R5 alert after low clear", alert, 0);
    endtask

    task automatic t_mask();
        int d;
        wr(A_CFG, 'h80);
        sample(0, 450);
        step();
        chk("R6 masked alert", alert, 0);
        rd(A_STAT, d);  chk("R6 status still set", d, 'h10);
        rd(A_HIST, d);
        wr(A_CFG, 'h00);
        step();
        chk("R6 no alert after unmask", alert, 0);
    endtask

    task automatic t_therm();
        int d;
        wr(A_THLIM + 5'd1, 600);
        sample(1, 601);
        step();
        chk("R10 therm_out high", therm_out, 1);
        chk("R5 therm no alert", alert, 0);
        rd(A_STAT, d);  chk("R2 therm bit1", d, 'h02);
        sample(1, 500);
        chk("R10 therm_out released", therm_out, 0);
        rd(A_STAT, d);  chk("R10 therm sticky", d, 'h02);
        rd(A_THST, d);  chk("R4 therm register", d, 'h2);
        rd(A_STAT, d);  chk("R4 therm cleared", d, 'h00);
        wr(A_THLIM + 5'd1, 'h7FF);
    endtask

    task automatic t_fault();
        int d;
        @(negedge clk); diode_fault = 3'b001;
        @(negedge clk); diode_fault = 3'b000;
        step();
        rd(A_FLST, d);  chk("R11 internal fault ignored", d, 0);
        chk("R11 no alert", alert, 0);
        @(negedge clk); diode_fault = 3'b100;
        @(negedge clk); diode_fault = 3'b000;
        step();
        chk("R5 alert on fault", alert, 1);
        rd(A_STAT, d);  chk("R2 fault bit2", d, 'h04);
        rd(A_FLST, d);  chk("R4 fault register", d, 'h4);
        step();
        chk("R5 alert after fault clear", alert, 0);
    endtask

    task automatic t_comp();
        int d;
        wr(A_CFG, 'hA0);
        sample(0, 401);
        step();
        chk("R7 comparator alert", alert, 1);
        rd(A_HIST, d);
        step();
        chk("R7 alert kept after status read", alert, 1);
        sample(0, 330);
        step();
        chk("R7 inside hysteresis", alert, 1);
        sample(0, 319);
        step();
        chk("R7 released below hysteresis", alert, 0);
        rd(A_HIST, d);  chk("R7 no new high status", d, 0);
        wr(A_CFG, 'h00);
    endtask

    task automatic t_range();
        int d;
        wr(A_HILIM + 5'd1, 1500);
        sample(1, 2000);
        chk("R9 shutdown normal range", sys_shdn, 1);
        rd(A_STAT, d);  chk("R8 saturated code", d, 'h01);
        step();
        chk("R9 shutdown not on alert", alert, 0);
        sample(0, 10);
        chk("R9 other channel no effect", sys_shdn, 1);
        wr(A_CFG, 'h04);
        rd(A_CFG, d);   chk("R8 range bit readback", d, 'h04);
        sample(1, 1200);
        chk("R9 extended threshold", sys_shdn, 0);
        rd(A_STAT, d);  chk("R8 extended below limit", d, 'h00);
        sample(1, 2000);
        rd(A_STAT, d);  chk("R8 extended full code", d, 'h11);
        rd(A_HIST, d);  chk("R4 high channel1", d, 'h2);
        wr(A_CFG, 'h00);
        sample(1, 1200);
        chk("R8 normal range saturates", sys_shdn, 1);
        sample(1, 0);
        chk("R9 shutdown cleared", sys_shdn, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_high_low();
        t_mask();
        t_therm();
        t_fault();
        t_comp();
        t_range();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule